// File: doc/BRIEF.md
# Latch-Based Output Expander Controller

This controller widens a small set of pins into a large bank of output-only lines. A few shared data wires run to the D inputs of several external edge-triggered latches, and each latch has its own clock wire. With the default settings, two latches of eight bits give sixteen outputs from ten wires. The controller keeps an internal shadow copy of every expanded output. This copy is the only record of what the external latches hold, because none of the external pins are read back.

A caller sends one request on a valid/ready port. The request carries an output index and a one-bit value. The controller writes the value into the addressed shadow bit. It then places the complete shadow group of that latch on the data wires, not only the bit that changed. Next it raises that latch's clock for a set time and lowers it again. Before the clock rises, the data must stay stable for a setup time. After the clock falls, the data must stay stable for a hold time. All three times are parameters counted in clock cycles. The port accepts a request only while the sequencer is idle. A request presented during a strobe sequence waits: it is accepted in the first idle cycle and must be held unchanged until then. Every expanded line reports output direction.

Top module: `latch_expander`

## Requirements
- R1: While reset is held and after it is released, the shadow vector, all data wires and all clock wires are low, and `req_ready` is high.
- R2: An accepted request with index i below GROUPS×WIDTH sets shadow bit i to the request value and leaves every other shadow bit unchanged. Bit i belongs to latch i / WIDTH, at data wire i mod WIDTH.
- R3: From the cycle after acceptance until the next acceptance, data wire k carries shadow bit (latch×WIDTH + k) of the addressed latch, including the bits that did not change.
- R4: One accepted in-range request produces exactly one high pulse, on the addressed latch's clock wire only. At most one clock wire is ever high.
- R5: After acceptance the clock wires stay low for exactly SETUP_CYC cycles, and the data wires do not change during that time.
- R6: The addressed clock wire stays high for exactly HIGH_CYC consecutive cycles, and the data wires do not change during that time.
- R7: After the clock falls, the data wires stay unchanged and `req_ready` stays low for exactly HOLD_CYC cycles. Then `req_ready` returns high.
- R8: `req_ready` is low from acceptance until the sequence ends. A request held valid during that time is not taken and does not change the shadow. It is accepted in the first cycle that `req_ready` is high.
- R9: A request whose index is GROUPS×WIDTH or larger is accepted and then dropped. The shadow, data wires and clock wires do not change, and `req_ready` stays high.
- R10: `pin_is_output` reports 1 for every expanded output.
- R11: When idle, the data wires keep the group that was last sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; a request is taken on valid and ready |
| req_index | input | IDX_W | Expanded output index; values of GROUPS×WIDTH or more are out of range |
| req_value | input | 1 | Level to write |
| latch_data | output | WIDTH | Shared data wires to all latch D inputs |
| latch_strobe | output | GROUPS | One clock wire per latch; bit g drives latch g |
| shadow_q | output | GROUPS×WIDTH | Shadow copy of all expanded outputs |
| pin_is_output | output | GROUPS×WIDTH | Direction of each expanded output; always 1 |

## Verification
The hardest case to reach is a request that is already waiting while a sequence is running. In that case the shadow must stay unchanged for every cycle of setup, strobe and hold, and the waiting request must be taken on the exact cycle that ready returns. To reach it, the stimulus keeps valid high right after an acceptance and switches to a second index. It then watches the shadow on every busy cycle and measures the second sequence in full. Out-of-range indices are sent between normal writes, so that a dropped request can be seen at the ports.

// File: rtl/lexp_pkg.sv
package lexp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_HIGH  = 2'd2,
    ST_HOLD  = 2'd3
  } seq_state_t;

  function automatic int unsigned clog2_min1(input int unsigned v);
    int unsigned r;
    r = 0;
    while ((32'd1 << r) < v) r++;
    return (r == 0) ? 1 : r;
  endfunction
endpackage

// File: rtl/lexp_decode.sv
module lexp_decode #(
  parameter int GROUPS = 2,
  parameter int WIDTH  = 8,
  parameter int IDX_W  = 5,
  parameter int GRP_W  = 1,
  parameter int BIT_W  = 3
) (
  input  logic [IDX_W-1:0] idx,
  output logic             in_range,
  output logic [GRP_W-1:0] grp,
  output logic [BIT_W-1:0] bit_sel
);
  localparam int unsigned TOTAL = GROUPS * WIDTH;

  int unsigned idx_u;
  always_comb begin
    idx_u    = 32'(idx);
    in_range = (idx_u < TOTAL);
    grp      = GRP_W'(idx_u / WIDTH);
    bit_sel  = BIT_W'(idx_u % WIDTH);
  end

  always_comb begin
    if (in_range) begin
      assert (32'(grp) < GROUPS) else $error("p_grp_range_r2 failed");
    end
  end
endmodule

// File: rtl/lexp_shadow.sv
module lexp_shadow #(
  parameter int GROUPS = 2,
  parameter int WIDTH  = 8,
  parameter int GRP_W  = 1,
  parameter int BIT_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [GRP_W-1:0]          wr_grp,
  input  logic [BIT_W-1:0]          wr_bit,
  input  logic                      wr_value,
  output logic [GROUPS*WIDTH-1:0]   shadow,
  output logic [WIDTH-1:0]          next_group
);
  localparam int TOTAL = GROUPS * WIDTH;

  logic [TOTAL-1:0] shadow_d;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic hit;
      assign hit = wr_en && (wr_grp == GRP_W'(g)) && (wr_bit == BIT_W'(b));
      assign shadow_d[g*WIDTH + b] = hit ? wr_value : shadow[g*WIDTH + b];
    end
  end

  always_comb begin
    next_group = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (wr_grp == GRP_W'(g)) next_group = shadow_d[g*WIDTH +: WIDTH];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) shadow <= '0;
    else        shadow <= shadow_d;
  end

  p_shadow_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(shadow));
  p_single_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ($countones(shadow ^ $past(shadow)) <= 1));
endmodule

// File: rtl/lexp_sequencer.sv
module lexp_sequencer
  import lexp_pkg::*;
#(
  parameter int GROUPS    = 2,
  parameter int WIDTH     = 8,
  parameter int GRP_W     = 1,
  parameter int SETUP_CYC = 2,
  parameter int HIGH_CYC  = 3,
  parameter int HOLD_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [GRP_W-1:0]  start_grp,
  input  logic [WIDTH-1:0]  start_data,
  output logic              idle,
  output logic [WIDTH-1:0]  data_q,
  output logic [GROUPS-1:0] strobe
);
  localparam int MAX_A = (SETUP_CYC > HIGH_CYC) ? SETUP_CYC : HIGH_CYC;
  localparam int MAX_C = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int CNT_W = clog2_min1(MAX_C + 1);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [GRP_W-1:0] grp_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt == '0);
  assign idle     = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      grp_q  <= '0;
      data_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_SETUP;
            cnt    <= CNT_W'(SETUP_CYC - 1);
            grp_q  <= start_grp;
            data_q <= start_data;
          end
        end
        ST_SETUP: begin
          if (cnt_zero) begin
            state <= ST_HIGH;
            cnt   <= CNT_W'(HIGH_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HIGH: begin
          if (cnt_zero) begin
            state <= ST_HOLD;
            cnt   <= CNT_W'(HOLD_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HOLD: begin
          if (cnt_zero) state <= ST_IDLE;
          else          cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_strobe
    assign strobe[g] = (state == ST_HIGH) && (grp_q == GRP_W'(g));
  end

  p_strobe_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe));
  p_idle_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (strobe == '0));
  p_data_steady_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe != '0) |=> $stable(data_q));
  p_hold_after_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((strobe == '0) && $past(strobe != '0)) |-> !idle);
  p_strobe_not_at_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start) |=> (strobe == '0));
endmodule

// File: rtl/latch_expander.sv
module latch_expander
  import lexp_pkg::*;
#(
  parameter int GROUPS    = 2,
  parameter int WIDTH     = 8,
  parameter int SETUP_CYC = 2,
  parameter int HIGH_CYC  = 3,
  parameter int HOLD_CYC  = 2,
  parameter int IDX_W     = clog2_min1(GROUPS * WIDTH) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [IDX_W-1:0]        req_index,
  input  logic                    req_value,
  output logic [WIDTH-1:0]        latch_data,
  output logic [GROUPS-1:0]       latch_strobe,
  output logic [GROUPS*WIDTH-1:0] shadow_q,
  output logic [GROUPS*WIDTH-1:0] pin_is_output
);
  localparam int TOTAL = GROUPS * WIDTH;
  localparam int GRP_W = clog2_min1(GROUPS);
  localparam int BIT_W = clog2_min1(WIDTH);

  logic             accept;
  logic             in_range;
  logic             wr_en;
  logic [GRP_W-1:0] dec_grp;
  logic [BIT_W-1:0] dec_bit;
  logic [WIDTH-1:0] next_group;
  logic             seq_idle;

  assign req_ready     = seq_idle;
  assign accept        = req_valid && req_ready;
  assign wr_en         = accept && in_range;
  assign pin_is_output = {TOTAL{1'b1}};

  lexp_decode #(
    .GROUPS(GROUPS), .WIDTH(WIDTH), .IDX_W(IDX_W), .GRP_W(GRP_W), .BIT_W(BIT_W)
  ) u_decode (
    .idx(req_index), .in_range(in_range), .grp(dec_grp), .bit_sel(dec_bit)
  );

  lexp_shadow #(
    .GROUPS(GROUPS), .WIDTH(WIDTH), .GRP_W(GRP_W), .BIT_W(BIT_W)
  ) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_grp(dec_grp), .wr_bit(dec_bit),
    .wr_value(req_value), .shadow(shadow_q), .next_group(next_group)
  );

  lexp_sequencer #(
    .GROUPS(GROUPS), .WIDTH(WIDTH), .GRP_W(GRP_W),
    .SETUP_CYC(SETUP_CYC), .HIGH_CYC(HIGH_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(wr_en), .start_grp(dec_grp),
    .start_data(next_group), .idle(seq_idle), .data_q(latch_data),
    .strobe(latch_strobe)
  );

  p_oob_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_range) |=> ($stable(shadow_q) && req_ready));
  p_busy_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !req_ready);
  p_idle_data_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !accept) |=> $stable(latch_data));
endmodule

// File: tb/latch_expander_tb.sv
`timescale 1ns/1ps
module latch_expander_tb;
  localparam int GROUPS = 2;
  localparam int WIDTH  = 8;
  localparam int SETUP  = 2;
  localparam int HIGH   = 3;
  localparam int HOLD   = 2;
  localparam int TOTAL  = GROUPS * WIDTH;
  localparam int IDX_W  = 5;
  localparam int NVEC   = 10;

  localparam int VEC_IDX [NVEC] = '{3, 12, 7, 8, 3, 15, 0, 12, 9, 15};
  localparam bit VEC_VAL [NVEC] = '{1, 1, 1, 1, 0, 1, 1, 0, 1, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [IDX_W-1:0] req_index = '0;
  logic req_value = 1'b0;
  logic req_ready;
  logic [WIDTH-1:0] latch_data;
  logic [GROUPS-1:0] latch_strobe;
  logic [TOTAL-1:0] shadow_q;
  logic [TOTAL-1:0] pin_is_output;

  int checks = 0;
  int errors = 0;
  logic [TOTAL-1:0] model = '0;

  always #2.5 clk = ~clk;

  latch_expander #(
    .GROUPS(GROUPS), .WIDTH(WIDTH), .SETUP_CYC(SETUP), .HIGH_CYC(HIGH), .HOLD_CYC(HOLD)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_index(req_index), .req_value(req_value), .latch_data(latch_data),
    .latch_strobe(latch_strobe), .shadow_q(shadow_q), .pin_is_output(pin_is_output)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [WIDTH-1:0] grp_of(input int g);
    return model[g*WIDTH +: WIDTH];
  endfunction

  // Called at the negedge following the accepting edge; measures the full sequence.
  task automatic run_seq(input int g);
    int setup_n = 0;
    int high_n  = 0;
    int hold_n  = 0;
    logic [WIDTH-1:0] exp_d = grp_of(g);
    chk(shadow_q == model, "R2 shadow after write", 64'(shadow_q), 64'(model));
    while (latch_strobe == '0 && setup_n < 50) begin
      chk(latch_data == exp_d, "R3 data during setup", 64'(latch_data), 64'(exp_d));
      chk(!req_ready, "R8 ready low in setup", 64'(req_ready), 64'd0);
      setup_n++;
      @(negedge clk);
    end
    chk(setup_n == SETUP, "R5 setup cycles", 64'(setup_n), 64'(SETUP));
    while (latch_strobe != '0 && high_n < 50) begin
      chk(latch_strobe == GROUPS'(1 << g), "R4 strobe select", 64'(latch_strobe), 64'(1 << g));
      chk(latch_data == exp_d, "R6 data stable in strobe", 64'(latch_data), 64'(exp_d));
      high_n++;
      @(negedge clk);
    end
    chk(high_n == HIGH, "R6 strobe high cycles", 64'(high_n), 64'(HIGH));
    while (!req_ready && hold_n < 50) begin
      chk(latch_strobe == '0, "R4 single pulse", 64'(latch_strobe), 64'd0);
      chk(latch_data == exp_d, "R7 data held", 64'(latch_data), 64'(exp_d));
      hold_n++;
      @(negedge clk);
    end
    chk(hold_n == HOLD, "R7 hold cycles", 64'(hold_n), 64'(HOLD));
  endtask

  task automatic do_req(input int idx, input bit val);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_index = IDX_W'(idx);
    req_value = val;
    @(negedge clk);
    req_valid = 1'b0;
    if (idx < TOTAL) begin
      model[idx] = val;
      run_seq(idx / WIDTH);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [TOTAL-1:0] snap;
    logic [WIDTH-1:0] dsnap;
    repeat (3) @(negedge clk);
    chk(shadow_q == '0 && latch_data == '0 && latch_strobe == '0, "R1 in reset",
        64'({shadow_q, latch_data, latch_strobe}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(shadow_q == '0 && latch_data == '0 && latch_strobe == '0 && req_ready,
        "R1 after reset", 64'({shadow_q, latch_data, latch_strobe, req_ready}), 64'd1);
    chk(pin_is_output == '1, "R10 direction", 64'(pin_is_output), 64'hFFFF);

    // Table walk
    for (int i = 0; i < NVEC; i++) do_req(VEC_IDX[i], VEC_VAL[i]);

    // R11: idle data kept
    dsnap = latch_data;
    repeat (4) @(negedge clk);
    chk(latch_data == dsnap && latch_strobe == '0, "R11 idle data kept",
        64'(latch_data), 64'(dsnap));

    // R9: out-of-range requests
    for (int k = 0; k < 2; k++) begin
      snap = shadow_q;
      dsnap = latch_data;
      @(negedge clk);
      req_valid = 1'b1;
      req_index = (k == 0) ? IDX_W'(TOTAL) : '1;
      req_value = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      for (int c = 0; c < 4; c++) begin
        chk(shadow_q == snap && latch_data == dsnap && latch_strobe == '0 && req_ready,
            "R9 out of range dropped", 64'({shadow_q, latch_strobe, req_ready}),
            64'({snap, 2'b00, 1'b1}));
        @(negedge clk);
      end
    end

    // R8: request held during busy sequence
    @(negedge clk);
    req_valid = 1'b1;
    req_index = IDX_W'(5);
    req_value = 1'b1;
    @(negedge clk);
    model[5] = 1'b1;
    req_index = IDX_W'(10);
    req_value = 1'b1;
    snap = model;
    while (!req_ready) begin
      chk(shadow_q == snap, "R8 busy request not taken", 64'(shadow_q), 64'(snap));
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
    model[10] = 1'b1;
    run_seq(1);
    chk(shadow_q == model, "R8 held request accepted", 64'(shadow_q), 64'(model));

    // R3: clearing a bit keeps its neighbours on the wires
    do_req(10, 1'b0);
    chk(latch_data == grp_of(1), "R3 neighbours kept", 64'(latch_data), 64'(grp_of(1)));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule